// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This unit performs lane-parallel arithmetic on two 32-bit operands. It splits them into two 16-bit halfword lanes or four 8-bit byte lanes. Each lane is computed independently, so no carry or borrow crosses a lane boundary. Six arithmetic flavours are provided: signed or unsigned, each with wrap-around (modulo), clamping (saturating) or halving. Two cross operations add on one halfword and subtract on the other.

A 4-bit greater-or-equal flag register is updated only by the modulo flavours. GE bit i belongs to byte i, which is bits 8i+7..8i. A separate byte-merge request uses these flags to pick each result byte from either operand. Every accepted strobe gives a registered result and an output-valid pulse on the following cycle. Encodings that are not defined are reported as illegal.

Top module: `simd_addsub_unit`

## Requirements
- R1: One clock after `in_valid` is high, `out_valid` is high and `result`/`illegal` hold the outcome of that request. In a cycle after one with `in_valid` low, `out_valid` is low.
- R2: When `merge_req`=0 and `flavour`[1:0]=00 (codes 0 and 4), the request is illegal. The unit reports `illegal`=1 and `result`=0, and the GE flags are unchanged. The legal flavour codes are 1 signed modulo, 2 signed saturating, 3 signed halving, 5 unsigned modulo, 6 unsigned saturating and 7 unsigned halving.
- R3: When `merge_req`=0 and `opcode` is 5 or 6, the request is illegal, with the same reporting as in R2. The legal opcodes are 0 add on both halfwords, 1 subtract low halfword with add high halfword, 2 add low halfword with subtract high halfword, 3 subtract on both halfwords, 4 add on four bytes and 7 subtract on four bytes.
- R4: Each lane result is formed from the same bit positions of `opa` and `opb` and is written to those same positions. In modulo flavours the lane result is the low lane bits of the sum or difference (`opa` minus `opb`).
- R5: Opcode 1 gives `opa`-`opb` on bits 15..0 and `opa`+`opb` on bits 31..16. Opcode 2 gives the opposite assignment.
- R6: In signed saturating lanes, a result outside the signed lane range is clamped to 0x7FFF/0x8000 for halfwords or 0x7F/0x80 for bytes.
- R7: In unsigned saturating lanes, an add that carries out becomes all ones, and a subtract with `opa` lane < `opb` lane becomes zero.
- R8: Halving lanes return the full-precision sum or difference shifted right by one. The shift is arithmetic for signed flavours and logical (of the one-bit-wider value) for unsigned flavours.
- R9: In signed modulo, a lane whose full-precision result is ≥ 0 sets its GE bits, and clears them otherwise. A halfword lane h drives GE bits 2h and 2h+1, and a byte lane i drives GE bit i.
- R10: In unsigned modulo, an add lane sets its GE bit(s) on carry out, and a subtract lane sets them when `opa` lane ≥ `opb` lane. Otherwise the GE bits are cleared.
- R11: The GE flags reset to 0. They are left unchanged by the saturating and halving flavours, by illegal requests, by merges and by idle cycles.
- R12: With `merge_req`=1, `flavour` and `opcode` are ignored and `illegal`=0. Result byte i is `opa` byte i when GE bit i is 1 and `opb` byte i otherwise, using the flags held before the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| merge_req | input | 1 | Selects byte merge instead of arithmetic |
| flavour | input | 3 | Arithmetic flavour code |
| opcode | input | 3 | Lane operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| out_valid | output | 1 | Result valid pulse |
| result | output | 32 | Registered result |
| ge_flags | output | 4 | Greater-or-equal flag register |
| illegal | output | 1 | Request encoding was illegal |

## Verification
On every cycle the assertions check the one-cycle valid timing and the illegal reporting for bad flavour and opcode codes. They also check that the GE flags stay unchanged across idle, non-modulo, illegal and merge requests, and that the low result byte of a merge follows the prior GE bit. The per-lane arithmetic cannot be checked by the assertions, and only the bench's scenarios and its reference model show it. That covers the signed and unsigned clamping limits, halving with arithmetic versus logical shift, the cross-halfword operations and the GE values produced from the true sign, carry or borrow.

// File: rtl/simd_pkg.sv
package simd_pkg;

   localparam int CODE_W = 3;

   localparam logic [CODE_W-1:0] OP_ADD_HH = 3'd0;
   localparam logic [CODE_W-1:0] OP_SUB_LO = 3'd1;
   localparam logic [CODE_W-1:0] OP_SUB_HI = 3'd2;
   localparam logic [CODE_W-1:0] OP_SUB_HH = 3'd3;
   localparam logic [CODE_W-1:0] OP_ADD_B  = 3'd4;
   localparam logic [CODE_W-1:0] OP_BAD_5  = 3'd5;
   localparam logic [CODE_W-1:0] OP_BAD_6  = 3'd6;
   localparam logic [CODE_W-1:0] OP_SUB_B  = 3'd7;

   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_WRAP = 2'd1,
      K_CLMP = 2'd2,
      K_HALF = 2'd3
   } lane_kind_t;

   typedef struct packed {
      logic       bad;
      logic       sgn;
      lane_kind_t kind;
      logic       bytes;
      logic       sub_lo;
      logic       sub_hi;
      logic       ge_wr;
   } simd_ctl_t;

endpackage

// File: rtl/simd_decode.sv
module simd_decode
   import simd_pkg::*;
(
   input  logic              merge_req,
   input  logic [CODE_W-1:0] flavour,
   input  logic [CODE_W-1:0] opcode,
   output simd_ctl_t         ctl
);

   logic flav_bad;
   logic op_bad;

   always_comb begin
      flav_bad = (flavour[1:0] == 2'b00);
      op_bad   = (opcode == OP_BAD_5) || (opcode == OP_BAD_6);

      ctl.bad    = !merge_req && (flav_bad || op_bad);
      ctl.sgn    = !flavour[2];
      ctl.kind   = lane_kind_t'(flavour[1:0]);
      ctl.bytes  = (opcode == OP_ADD_B) || (opcode == OP_SUB_B);
      ctl.sub_lo = (opcode == OP_SUB_LO) || (opcode == OP_SUB_HH) || (opcode == OP_SUB_B);
      ctl.sub_hi = (opcode == OP_SUB_HI) || (opcode == OP_SUB_HH) || (opcode == OP_SUB_B);
      ctl.ge_wr  = !merge_req && !flav_bad && !op_bad && (lane_kind_t'(flavour[1:0]) == K_WRAP);
   end

endmodule

// File: rtl/simd_lane.sv
module simd_lane
   import simd_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         sgn,
   input  lane_kind_t   kind,
   output logic [W-1:0] res,
   output logic         flag
);

   localparam int EW = W + 1;

   logic [EW-1:0] ax;
   logic [EW-1:0] bx;
   logic [EW-1:0] ext;
   logic [W-1:0]  clamp_v;
   logic          ovf;
   logic [W-1:0]  sat_v;

   always_comb begin
      ax  = {sgn & a[W-1], a};
      bx  = {sgn & b[W-1], b};
      ext = sub ? (ax - bx) : (ax + bx);

      // signed: wide sign bit is the true sign; unsigned: carry or borrow
      if (sgn || sub) flag = !ext[W];
      else            flag = ext[W];

      if (sgn) begin
         ovf     = ext[W] ^ ext[W-1];
         clamp_v = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      end else begin
         ovf     = ext[W];
         clamp_v = sub ? {W{1'b0}} : {W{1'b1}};
      end
      sat_v = ovf ? clamp_v : ext[W-1:0];

      unique case (kind)
         K_CLMP:  res = sat_v;
         K_HALF:  res = ext[W:1];
         default: res = ext[W-1:0];
      endcase
   end

endmodule

// File: rtl/simd_merge.sv
module simd_merge #(
   parameter int NUM_BYTES = 4,
   parameter int BYTE_W    = 8
) (
   input  logic [NUM_BYTES-1:0]        sel,
   input  logic [NUM_BYTES*BYTE_W-1:0] a,
   input  logic [NUM_BYTES*BYTE_W-1:0] b,
   output logic [NUM_BYTES*BYTE_W-1:0] y
);

   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
      assign y[i*BYTE_W +: BYTE_W] = sel[i] ? a[i*BYTE_W +: BYTE_W] : b[i*BYTE_W +: BYTE_W];
   end

endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
   import simd_pkg::*;
#(
   parameter int NUM_BYTES = 4,
   parameter int BYTE_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic                        merge_req,
   input  logic [2:0]                  flavour,
   input  logic [2:0]                  opcode,
   input  logic [NUM_BYTES*BYTE_W-1:0] opa,
   input  logic [NUM_BYTES*BYTE_W-1:0] opb,
   output logic                        out_valid,
   output logic [NUM_BYTES*BYTE_W-1:0] result,
   output logic [NUM_BYTES-1:0]        ge_flags,
   output logic                        illegal
);

   localparam int DATA_W   = NUM_BYTES * BYTE_W;
   localparam int HALF_W   = 2 * BYTE_W;
   localparam int NUM_HALF = NUM_BYTES / 2;

   initial begin
      if (NUM_BYTES < 2 || (NUM_BYTES % 2) != 0)
         $error("simd_addsub_unit: NUM_BYTES must be even and at least 2");
      if (BYTE_W < 2)
         $error("simd_addsub_unit: BYTE_W must be at least 2");
   end

   simd_ctl_t ctl;

   simd_decode i_dec (
      .merge_req (merge_req),
      .flavour   (flavour),
      .opcode    (opcode),
      .ctl       (ctl)
   );

   logic [DATA_W-1:0]    byte_res;
   logic [NUM_BYTES-1:0] byte_flag;
   logic [DATA_W-1:0]    half_res;
   logic [NUM_BYTES-1:0] half_ge;

   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_blane
      simd_lane #(.W(BYTE_W)) i_lane (
         .a    (opa[i*BYTE_W +: BYTE_W]),
         .b    (opb[i*BYTE_W +: BYTE_W]),
         .sub  (ctl.sub_lo),
         .sgn  (ctl.sgn),
         .kind (ctl.kind),
         .res  (byte_res[i*BYTE_W +: BYTE_W]),
         .flag (byte_flag[i])
      );
   end

   for (genvar h = 0; h < NUM_HALF; h++) begin : g_hlane
      logic hflag;
      logic hsub;
      if ((h % 2) == 0) begin : g_even
         assign hsub = ctl.sub_lo;
      end else begin : g_odd
         assign hsub = ctl.sub_hi;
      end
      simd_lane #(.W(HALF_W)) i_lane (
         .a    (opa[h*HALF_W +: HALF_W]),
         .b    (opb[h*HALF_W +: HALF_W]),
         .sub  (hsub),
         .sgn  (ctl.sgn),
         .kind (ctl.kind),
         .res  (half_res[h*HALF_W +: HALF_W]),
         .flag (hflag)
      );
      assign half_ge[2*h +: 2] = {hflag, hflag};
   end

   logic [DATA_W-1:0] merged;

   simd_merge #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) i_merge (
      .sel (ge_flags),
      .a   (opa),
      .b   (opb),
      .y   (merged)
   );

   logic [DATA_W-1:0]    next_res;
   logic [NUM_BYTES-1:0] next_ge;

   always_comb begin
      next_ge = ctl.bytes ? byte_flag : half_ge;
      if (merge_req)    next_res = merged;
      else if (ctl.bad) next_res = '0;
      else              next_res = ctl.bytes ? byte_res : half_res;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         illegal   <= 1'b0;
         ge_flags  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result  <= next_res;
            illegal <= ctl.bad;
            if (ctl.ge_wr) ge_flags <= next_ge;
         end
      end
   end

endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
   parameter int NUM_BYTES = 4,
   parameter int BYTE_W    = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_valid,
   input logic                        merge_req,
   input logic [2:0]                  flavour,
   input logic [2:0]                  opcode,
   input logic [NUM_BYTES*BYTE_W-1:0] opa,
   input logic [NUM_BYTES*BYTE_W-1:0] opb,
   input logic                        out_valid,
   input logic [NUM_BYTES*BYTE_W-1:0] result,
   input logic [NUM_BYTES-1:0]        ge_flags,
   input logic                        illegal
);

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R1

   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R1

   AST_BAD_FLAVOUR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !merge_req && flavour[1:0] == 2'b00) |=> (illegal && result == '0)); // R2

   AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !merge_req && (opcode == 3'd5 || opcode == 3'd6)) |=> illegal); // R3

   AST_GE_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(ge_flags)); // R11

   AST_GE_HOLD_NONWRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (merge_req || flavour[1:0] != 2'b01 || opcode == 3'd5 || opcode == 3'd6))
      |=> $stable(ge_flags)); // R11

   AST_MERGE_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && merge_req) |=> (!illegal && result[BYTE_W-1:0] ==
         ($past(ge_flags[0]) ? $past(opa[BYTE_W-1:0]) : $past(opb[BYTE_W-1:0])))); // R12

endmodule

bind simd_addsub_unit simd_addsub_chk #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .merge_req (merge_req),
   .flavour   (flavour),
   .opcode    (opcode),
   .opa       (opa),
   .opb       (opb),
   .out_valid (out_valid),
   .result    (result),
   .ge_flags  (ge_flags),
   .illegal   (illegal)
);

// File: tb/test_simd_addsub_unit.sv
`timescale 1ns/100ps
module test_simd_addsub_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        merge_req = 1'b0;
   logic [2:0]  flavour = 3'd1;
   logic [2:0]  opcode = 3'd0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic        out_valid;
   logic [31:0] result;
   logic [3:0]  ge_flags;
   logic        illegal;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 0;
   string cur_req = "R4";
   string exp_tag = "R4";

   logic        exp_v = 1'b0;
   logic [31:0] exp_res = '0;
   logic [3:0]  exp_ge = '0;
   logic        exp_ill = 1'b0;

   always #2.5 clk = ~clk;

   simd_addsub_unit i_simd_addsub_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .merge_req(merge_req),
      .flavour(flavour), .opcode(opcode), .opa(opa), .opb(opb),
      .out_valid(out_valid), .result(result), .ge_flags(ge_flags), .illegal(illegal)
   );

   // behavioural lane model
   function automatic void lane_ref(input longint a, input longint b, input int w,
                                    input bit sub, input int flav,
                                    output longint r, output bit g);
      longint mask = (longint'(1) << w) - 1;
      bit     sg = (flav < 4);
      int     k = flav % 4;
      longint av = a;
      longint bv = b;
      longint t;
      longint lo;
      longint hi;
      if (sg && a >= (longint'(1) << (w-1))) av = a - (longint'(1) << w);
      if (sg && b >= (longint'(1) << (w-1))) bv = b - (longint'(1) << w);
      t = sub ? av - bv : av + bv;
      g = 1'b0;
      if (k == 1) begin
         r = t & mask;
         if (sg || sub) g = (t >= 0);
         else           g = (t > mask);
      end else if (k == 2) begin
         lo = sg ? -(longint'(1) << (w-1)) : 0;
         hi = sg ? (longint'(1) << (w-1)) - 1 : mask;
         if (t < lo) t = lo;
         if (t > hi) t = hi;
         r = t & mask;
      end else begin
         if (sg) r = (t >>> 1) & mask;
         else    r = ((t & ((mask << 1) | 1)) >> 1) & mask;
      end
   endfunction

   function automatic logic [36:0] ref_op(input logic [31:0] a, input logic [31:0] b,
                                          input int flav, input int op, input bit mrg,
                                          input logic [3:0] gin);
      logic [31:0] r = '0;
      logic [3:0]  g = gin;
      longint      lr;
      bit          lg;
      bit          sub;
      if (mrg) begin
         for (int i = 0; i < 4; i++) r[8*i +: 8] = gin[i] ? a[8*i +: 8] : b[8*i +: 8];
         return {1'b0, gin, r};
      end
      if ((flav % 4) == 0 || op == 5 || op == 6) return {1'b1, gin, 32'h0};
      if (op == 4 || op == 7) begin
         for (int i = 0; i < 4; i++) begin
            lane_ref(longint'(a[8*i +: 8]), longint'(b[8*i +: 8]), 8, op == 7, flav, lr, lg);
            r[8*i +: 8] = lr[7:0];
            if ((flav % 4) == 1) g[i] = lg;
         end
      end else begin
         for (int h = 0; h < 2; h++) begin
            sub = (op == 3) || (op == 1 && h == 0) || (op == 2 && h == 1);
            lane_ref(longint'(a[16*h +: 16]), longint'(b[16*h +: 16]), 16, sub, flav, lr, lg);
            r[16*h +: 16] = lr[15:0];
            if ((flav % 4) == 1) g[2*h +: 2] = {lg, lg};
         end
      end
      return {1'b0, g, r};
   endfunction

   // reference model, advanced on every clock
   always @(posedge clk) begin
      logic [36:0] m;
      if (!rst_n) begin
         exp_v  <= 1'b0;
         exp_ge <= '0;
         exp_ill <= 1'b0;
         exp_res <= '0;
      end else begin
         exp_v   <= in_valid;
         exp_tag <= cur_req;
         if (in_valid) begin
            m = ref_op(opa, opb, int'(flavour), int'(opcode), merge_req, exp_ge);
            exp_ill <= m[36];
            exp_ge  <= m[35:32];
            exp_res <= m[31:0];
         end
      end
   end

   // comparison on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_checks++;
         if (out_valid !== exp_v || ge_flags !== exp_ge ||
             (exp_v && (result !== exp_res || illegal !== exp_ill))) begin
            n_errors++;
            $display("FAIL %s model: actual v=%b res=%h ge=%b ill=%b expected v=%b res=%h ge=%b ill=%b",
                     exp_tag, out_valid, result, ge_flags, illegal,
                     exp_v, exp_res, exp_ge, exp_ill);
         end
      end
   end

   task automatic issue(input string tag, input bit mrg, input logic [2:0] fl,
                        input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      cur_req   = tag;
      in_valid  = 1'b1;
      merge_req = mrg;
      flavour   = fl;
      opcode    = op;
      opa       = a;
      opb       = b;
      @(negedge clk);
      in_valid  = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [31:0] er, input logic [3:0] eg,
                      input logic ei);
      n_checks++;
      if (out_valid !== 1'b1 || result !== er || ge_flags !== eg || illegal !== ei) begin
         n_errors++;
         $display("FAIL %s: actual v=%b res=%h ge=%b ill=%b expected v=1 res=%h ge=%b ill=%b",
                  tag, out_valid, result, ge_flags, illegal, er, eg, ei);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_checks++;
      if (ge_flags !== 4'b0000 || out_valid !== 1'b0) begin
         n_errors++;
         $display("FAIL R11 reset: actual ge=%b v=%b expected ge=0000 v=0", ge_flags, out_valid);
      end

      issue("R4", 0, 3'd5, 3'd4, 32'h01FF80FF, 32'h01010101);
      chk("R4", 32'h02008100, 4'b0101, 0);
      issue("R10", 0, 3'd5, 3'd7, 32'h05050505, 32'h06050405);
      chk("R10", 32'hFF000100, 4'b0111, 0);
      issue("R5", 0, 3'd1, 3'd1, 32'h00050005, 32'h00010003);
      chk("R5", 32'h00060002, 4'b1111, 0);
      issue("R5", 0, 3'd1, 3'd2, 32'h00050005, 32'h00070003);
      chk("R5", 32'hFFFE0008, 4'b0011, 0);
      issue("R6", 0, 3'd2, 3'd0, 32'h7FFF8000, 32'h00018000);
      chk("R6", 32'h7FFF8000, 4'b0011, 0);
      issue("R6", 0, 3'd2, 3'd7, 32'h807F0010, 32'h01FF8020);
      chk("R6", 32'h807F7FF0, 4'b0011, 0);
      issue("R7", 0, 3'd6, 3'd7, 32'h10FF0510, 32'h20010510);
      chk("R7", 32'h00FE0000, 4'b0011, 0);
      issue("R7", 0, 3'd6, 3'd0, 32'hFFF00001, 32'h00200002);
      chk("R7", 32'hFFFF0003, 4'b0011, 0);
      issue("R8", 0, 3'd3, 3'd0, 32'h80000003, 32'h80000004);
      chk("R8", 32'h80000003, 4'b0011, 0);
      issue("R8", 0, 3'd7, 3'd3, 32'h00000000, 32'h00010002);
      chk("R8", 32'hFFFFFFFF, 4'b0011, 0);
      issue("R9", 0, 3'd1, 3'd0, 32'h80000001, 32'hFFFF0001);
      chk("R9", 32'h7FFF0002, 4'b0011, 0);
      issue("R10", 0, 3'd5, 3'd7, 32'h05050505, 32'h06050405);
      chk("R10", 32'hFF000100, 4'b0111, 0);
      issue("R12", 1, 3'd0, 3'd5, 32'h11223344, 32'hAABBCCDD);
      chk("R12", 32'hAA223344, 4'b0111, 0);
      issue("R2", 0, 3'd4, 3'd0, 32'h12345678, 32'h11111111);
      chk("R2", 32'h00000000, 4'b0111, 1);
      issue("R3", 0, 3'd1, 3'd6, 32'h12345678, 32'h11111111);
      chk("R3", 32'h00000000, 4'b0111, 1);
      cur_req = "R1";
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0) begin
         n_errors++;
         $display("FAIL R1 idle: actual v=%b expected v=0", out_valid);
      end

      for (int n = 0; n < 4000; n++) begin
         if (($urandom % 4) != 0) begin
            issue("R4", ($urandom % 8) == 0, 3'($urandom), 3'($urandom), $urandom, $urandom);
         end else begin
            cur_req = "R11";
            @(negedge clk);
         end
      end
      @(negedge clk);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule